// File: doc/BRIEF.md
# Seven-to-one parallel display link serializer

This block turns a 28-bit parallel pixel word into four serial data lanes and one forwarded clock lane for a flat panel link. The word holds 24 colour bits (eight each of red, green and blue) and the control lines for line sync, frame sync and data enable. It is captured on each falling edge of the pixel clock. A clock running at seven times the pixel rate then shifts the word out during the following pixel period. Each lane sends seven bits per pixel period, so a 65 MHz pixel clock gives 455 Mbps on every lane.

The fifth lane carries a clock with the same period as the pixel clock. Within every seven-bit frame it is high for the first four bit times and low for the last three, so a receiver can find where each frame starts. An active-low power-down input disables every output. After power-down ends, the outputs stay disabled until a complete word has been loaded into the lane shifters.

Both clocks come from outside the block. The bit clock must be phase-locked to the pixel clock, with exactly seven bit periods per pixel period. The block re-times its frame to the falling edge of the pixel clock, so the exact phase between the two clocks does not matter.

Top module: `pixel_link_serializer`

## Requirements
- R1: A word that is on `pix_word` at a falling edge of `pix_clk` appears on the lanes during the next pixel period. Its first bit time begins at the third rising edge of `bit_clk` after that falling edge.
- R2: Lane `n` carries input bits `7n` to `7n+6`: lane 0 carries bits 0 to 6, lane 1 bits 7 to 13, lane 2 bits 14 to 20, and lane 3 bits 21 to 27.
- R3: Each lane sends one bit per `bit_clk` cycle and seven bits per frame, lowest-numbered bit first. Bit time `j` (0 to 6) carries bit `7n+j`.
- R4: While enabled, `fclk_out` is 1 during bit times 0 to 3 and 0 during bit times 4 to 6 of every frame. It therefore has the same period as `pix_clk`.
- R5: Words on consecutive pixel periods go out in consecutive frames, and no frame mixes bits from two words.
- R6: When `pwr_dn_n` goes low, all output enables and all lane and clock outputs are 0 from the third `bit_clk` rising edge after the change.
- R7: After `pwr_dn_n` returns high, or after reset ends, the outputs stay disabled until the first frame load. The first enabled bit time is bit time 0 of a complete frame.
- R8: While `rst_n` is low, every output enable and every output is 0.
- R9: While powered down, changes on `pix_word` have no effect on any output, and none of those words appear after power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| pix_clk | input | 1 | Pixel clock; the word is captured on its falling edge |
| bit_clk | input | 1 | Bit-time clock at seven times the pixel rate, phase-locked to `pix_clk` |
| pwr_dn_n | input | 1 | Active-low power-down |
| pix_word | input | 28 | Parallel word: colour bits plus line sync, frame sync and data enable |
| lane_dat | output | 4 | Serial data, one bit per lane; 0 while disabled |
| lane_oe | output | 4 | Output enable for each data lane |
| fclk_out | output | 1 | Forwarded frame clock; 0 while disabled |
| fclk_oe | output | 1 | Output enable for the forwarded clock lane |

## Verification
The assertions assume that `pix_clk` lasts exactly seven `bit_clk` periods and that its edges fall between rising edges of `bit_clk`. They also assume that `pix_word` is steady around each falling edge of `pix_clk`. The frame-period and enable checks hold only under these conditions. The bench derives `pix_clk` from falling edges of `bit_clk`: it is high for four bit times and low for three. It changes the word only at rising edges of the pixel clock and changes `pwr_dn_n` only between pixel periods. This keeps every stimulus inside the clocking the assertions rely on.

// File: rtl/pls_pkg.sv
package pls_pkg;
  localparam int unsigned PLS_LANES = 4;
  localparam int unsigned PLS_SLOTS = 7;
  localparam int unsigned PLS_HIGH  = 4;

  function automatic int unsigned pls_cnt_w(input int unsigned slots);
    return (slots < 2) ? 1 : $clog2(slots);
  endfunction
endpackage

// File: rtl/pls_capture.sv
module pls_capture #(
  parameter int unsigned WORD_W = 28
) (
  input  logic              pix_clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] pix_word,
  output logic [WORD_W-1:0] cap_word
);
  logic [WORD_W-1:0] cap_d;

  always_comb cap_d = pix_word;

  // capture strobe is the falling pixel clock edge
  always_ff @(negedge pix_clk or negedge rst_n) begin
    if (!rst_n) cap_word <= '0;
    else        cap_word <= cap_d;
  end
endmodule

// File: rtl/pls_frame_timer.sv
module pls_frame_timer #(
  parameter int unsigned SLOTS = pls_pkg::PLS_SLOTS,
  parameter int unsigned HIGH  = pls_pkg::PLS_HIGH
) (
  input  logic bit_clk,
  input  logic rst_n,
  input  logic pix_clk,
  input  logic pwr_dn_n,
  output logic load_o,
  output logic powered_o,
  output logic armed_o,
  output logic fclk_o
);
  localparam int unsigned CW = pls_pkg::pls_cnt_w(SLOTS);
  localparam logic [CW-1:0] LAST   = CW'(SLOTS - 1);
  localparam logic [CW-1:0] HIGH_W = CW'(HIGH);

  logic [2:0]    ps_q, ps_d;
  logic [1:0]    pd_q, pd_d;
  logic [CW-1:0] slot_q, slot_d;
  logic          armed_q, armed_d;
  logic          fall, powered;

  always_comb begin
    ps_d    = {ps_q[1:0], pix_clk};
    pd_d    = {pd_q[0], pwr_dn_n};
    fall    = ps_q[2] & ~ps_q[1];
    powered = pd_q[1];
    if (!powered)           slot_d = '0;
    else if (fall)          slot_d = '0;
    else if (slot_q == LAST) slot_d = '0;
    else                    slot_d = slot_q + 1'b1;
    if (!powered)   armed_d = 1'b0;
    else if (fall)  armed_d = 1'b1;
    else            armed_d = armed_q;
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q    <= '0;
      pd_q    <= '0;
      slot_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      ps_q    <= ps_d;
      pd_q    <= pd_d;
      slot_q  <= slot_d;
      armed_q <= armed_d;
    end
  end

  assign load_o    = fall;
  assign powered_o = powered;
  assign armed_o   = armed_q;
  assign fclk_o    = armed_q && (slot_q < HIGH_W);

  // checker state: bit clocks since the last frame load
  logic [CW-1:0] since_q;
  logic          seen_q;
  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      since_q <= fall ? '0 : since_q + 1'b1;
      seen_q  <= seen_q | fall;
    end
  end

  // R5: frame loads recur exactly every SLOTS bit clocks
  a_r5_frame_period: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (fall && seen_q) |-> (since_q == LAST));
endmodule

// File: rtl/pls_lane_shifter.sv
module pls_lane_shifter #(
  parameter int unsigned SLOTS = pls_pkg::PLS_SLOTS
) (
  input  logic             bit_clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SLOTS-1:0] par_in,
  output logic             ser_o
);
  logic [SLOTS-1:0] sh_q, sh_d;

  always_comb begin
    if (load) sh_d = par_in;
    else      sh_d = {1'b0, sh_q[SLOTS-1:1]};
  end

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign ser_o = sh_q[0];
endmodule

// File: rtl/pixel_link_serializer.sv
module pixel_link_serializer #(
  parameter  int unsigned LANES  = pls_pkg::PLS_LANES,
  parameter  int unsigned SLOTS  = pls_pkg::PLS_SLOTS,
  parameter  int unsigned HIGH   = pls_pkg::PLS_HIGH,
  localparam int unsigned WORD_W = LANES * SLOTS
) (
  input  logic              rst_n,
  input  logic              pix_clk,
  input  logic              bit_clk,
  input  logic              pwr_dn_n,
  input  logic [WORD_W-1:0] pix_word,
  output logic [LANES-1:0]  lane_dat,
  output logic [LANES-1:0]  lane_oe,
  output logic              fclk_out,
  output logic              fclk_oe
);
  logic [WORD_W-1:0] cap_word;
  logic [WORD_W-1:0] word_s1_q, word_s2_q;
  logic [LANES-1:0]  ser;
  logic              load, powered, armed, fclk;

  pls_capture #(.WORD_W(WORD_W)) u_capture (
    .pix_clk  (pix_clk),
    .rst_n    (rst_n),
    .pix_word (pix_word),
    .cap_word (cap_word)
  );

  // two-stage transfer of the captured word into the bit clock domain
  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      word_s1_q <= '0;
      word_s2_q <= '0;
    end else begin
      word_s1_q <= cap_word;
      word_s2_q <= word_s1_q;
    end
  end

  pls_frame_timer #(.SLOTS(SLOTS), .HIGH(HIGH)) u_timer (
    .bit_clk   (bit_clk),
    .rst_n     (rst_n),
    .pix_clk   (pix_clk),
    .pwr_dn_n  (pwr_dn_n),
    .load_o    (load),
    .powered_o (powered),
    .armed_o   (armed),
    .fclk_o    (fclk)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pls_lane_shifter #(.SLOTS(SLOTS)) u_shift (
      .bit_clk (bit_clk),
      .rst_n   (rst_n),
      .load    (load),
      .par_in  (word_s2_q[g*SLOTS +: SLOTS]),
      .ser_o   (ser[g])
    );
    assign lane_dat[g] = armed & ser[g];
    assign lane_oe[g]  = armed;
  end

  assign fclk_out = fclk;
  assign fclk_oe  = armed;

  // R6: three sampled low levels of power-down force every output off
  a_r6_blank_on_powerdown: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (!pwr_dn_n && $past(!pwr_dn_n) && $past(!pwr_dn_n, 2)) |=>
    (!fclk_oe && lane_oe == '0 && lane_dat == '0 && !fclk_out));

  // R7: outputs become enabled only right after a powered frame load
  a_r7_enable_after_load: assert property (@(posedge bit_clk) disable iff (!rst_n)
    $rose(fclk_oe) |-> ($past(load) && $past(powered)));

  // R4: a powered load starts the high phase of the forwarded clock
  a_r4_clock_high_first: assert property (@(posedge bit_clk) disable iff (!rst_n)
    (load && powered) |=> (fclk_out && lane_oe == '1));
endmodule

// File: tb/pixel_link_serializer_bench.sv
module pixel_link_serializer_bench;
  localparam int BIT_PERIOD = 10;
  localparam int NVEC = 8;
  localparam logic [27:0] VECS [NVEC] = '{
    28'h0000000, 28'hFFFFFFF, 28'h5555555, 28'hAAAAAAA,
    28'h0000001, 28'h8000000, 28'h0204081, 28'h1234567
  };

  logic        rst_n, pix_clk, bit_clk, pwr_dn_n;
  logic [27:0] pix_word;
  logic [3:0]  lane_dat, lane_oe;
  logic        fclk_out, fclk_oe;
  int          n_chk, n_bad;

  pixel_link_serializer u_pixel_link_serializer (
    .rst_n    (rst_n),
    .pix_clk  (pix_clk),
    .bit_clk  (bit_clk),
    .pwr_dn_n (pwr_dn_n),
    .pix_word (pix_word),
    .lane_dat (lane_dat),
    .lane_oe  (lane_oe),
    .fclk_out (fclk_out),
    .fclk_oe  (fclk_oe)
  );

  initial bit_clk = 1'b0;
  always #(BIT_PERIOD/2) bit_clk = ~bit_clk;

  // One pixel period: pix_clk high for slots 0-3, low for 4-6; the new word
  // is driven at slot 0; slot j of the previous word is sampled at slot j.
  task automatic pix_cycle(input logic [27:0] nw, input logic [27:0] ew,
                           input logic [6:0] en_mask, input string tag);
    for (int j = 0; j < 7; j++) begin
      logic [3:0] exp_dat;
      logic       exp_clk, en;
      @(negedge bit_clk);
      pix_clk = (j < 4);
      if (j == 0) pix_word = nw;
      #1;
      en = en_mask[j];
      for (int l = 0; l < 4; l++) exp_dat[l] = en & ew[l*7 + j];
      exp_clk = en & (j < 4);
      n_chk++;
      if (lane_oe !== {4{en}} || fclk_oe !== en) begin
        n_bad++;
        $display("FAIL %s enable slot %0d: actual %b/%b expected %b/%b",
                 tag, j, lane_oe, fclk_oe, {4{en}}, en);
      end
      n_chk++;
      if (lane_dat !== exp_dat) begin
        n_bad++;
        $display("FAIL %s R2/R3 lane data slot %0d: actual %b expected %b",
                 tag, j, lane_dat, exp_dat);
      end
      n_chk++;
      if (fclk_out !== exp_clk) begin
        n_bad++;
        $display("FAIL %s R4 forwarded clock slot %0d: actual %b expected %b",
                 tag, j, fclk_out, exp_clk);
      end
    end
  endtask

  initial begin
    #(BIT_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog R1: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [27:0] prev;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; pwr_dn_n = 1'b1; pix_clk = 1'b0; pix_word = '0;

    // R8: reset state, everything disabled and low
    pix_cycle(28'h3C3C3C3, 28'h0, 7'h00, "R8");
    pix_cycle(28'h7FFFFFF, 28'h0, 7'h00, "R8");

    // R7: first period after reset stays disabled
    rst_n = 1'b1;
    prev = 28'h0ABCDEF;
    pix_cycle(prev, 28'h0, 7'h00, "R7");

    // R1 R2 R3 R4 R5: table of words, each checked one period later
    for (int i = 0; i < NVEC; i++) begin
      pix_cycle(VECS[i], prev, 7'h7F, "R1");
      prev = VECS[i];
    end

    // R6: power-down mid-stream, slots 0 and 1 still out, then blank
    pwr_dn_n = 1'b0;
    pix_cycle(28'hFFF0000, prev, 7'b0000011, "R6");
    // R9: words driven while down have no effect
    pix_cycle(28'h0F0F0F0, 28'h0, 7'h00, "R9");
    pix_cycle(28'hEEEEEEE, 28'h0, 7'h00, "R9");

    // R7: release; disabled for one period, then a full clean frame
    pwr_dn_n = 1'b1;
    pix_cycle(28'h7654321, 28'h0, 7'h00, "R7");
    pix_cycle(28'h1111111, 28'h7654321, 7'h7F, "R7");
    // R5: back-to-back distinct words stay in separate frames
    pix_cycle(28'h6DB6DB6, 28'h1111111, 7'h7F, "R5");
    pix_cycle(28'h0000000, 28'h6DB6DB6, 7'h7F, "R5");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule